// File: doc/BRIEF.md
# Program bank decoder with key-locked work RAM

This block sits between a 6502-style CPU bus and the cartridge memories. It decodes every CPU address into one of three targets. The upper 32 KB goes to program ROM, laid out as four 8 KB windows. Three of those windows follow bank registers loaded by the CPU, and the top window is pinned to the last ROM bank. The window at 0x6000 to 0x73FF goes to a 5 KB battery-backed work RAM. A small register file sits at 0x7EF0 to 0x7EFF.

The work RAM is split into three regions, and each region has its own permission register. A region answers reads and writes only while its permission register holds that region's key byte, and each region has a different key. Any other value locks the region, so its chip enable stays low and the data bus is left floating. Reset clears every permission register, so all regions start locked. Software unlocks a region by writing the key, and locks it again by writing anything else.

The outputs are combinational from the address and strobes. Register writes take effect at the rising clock edge on which the write strobe is sampled.

Top module: `prg_ram_decoder`

## Requirements
- R1: While reset is low and after its release, all bank registers and permission registers are zero. Every RAM region is therefore locked, and the ROM windows at 0x8000, 0xA000 and 0xC000 all select bank 0.
- R2: reg_sel_o is high exactly when cpu_addr_i lies in 0x7EF0..0x7EFF, regardless of the strobes.
- R3: A write to 0x7EFA, 0x7EFB or 0x7EFC loads cpu_data_i[7:2] as the bank for 0x8000-0x9FFF, 0xA000-0xBFFF or 0xC000-0xDFFF respectively. From the next cycle, prg_addr_o = {bank, cpu_addr_i[12:0]} in that window.
- R4: For cpu_addr_i in 0xE000..0xFFFF, the bank field prg_addr_o[18:13] is all ones (bank 63).
- R5: prg_ce_o is high exactly when cpu_addr_i[15] is 1 and cpu_rd_i is high.
- R6: For addresses in 0x6000..0x73FF, ram_addr_o = cpu_addr_i - 0x6000 (the low 13 address bits).
- R7: Region 0 (0x6000..0x67FF) is enabled only while permission register 0, written at 0x7EF7, holds 0xCA.
- R8: Region 1 (0x6800..0x6FFF) is enabled only while permission register 1, written at 0x7EF8, holds 0x69.
- R9: Region 2 (0x7000..0x73FF) is enabled only while permission register 2, written at 0x7EF9, holds 0x84.
- R10: An access to a locked region, whether read or write, keeps ram_ce_o and ram_we_o low. Writing a non-key value to a permission register re-locks its region.
- R11: Addresses 0x7400..0x7EEF raise none of ram_ce_o, reg_sel_o and prg_ce_o.
- R12: Writes to 0x7EF0..0x7EF6 and 0x7EFD..0x7EFF change no bank register and no permission register.
- R13: ram_ce_o is high only for an unlocked RAM address with cpu_rd_i or cpu_wr_i high. ram_we_o is ram_ce_o qualified by cpu_wr_i, and no access in the register window reaches the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_rd_i | input | 1 | Read strobe |
| cpu_wr_i | input | 1 | Write strobe |
| prg_addr_o | output | 19 | Program ROM byte address {bank, offset} |
| prg_ce_o | output | 1 | Program ROM chip enable (reads only) |
| ram_addr_o | output | 13 | Work RAM byte address |
| ram_ce_o | output | 1 | Work RAM chip enable; low leaves the bus open |
| ram_we_o | output | 1 | Work RAM write enable |
| reg_sel_o | output | 1 | Register window selected |

## Verification
Assertions check several rules on every cycle. The RAM write enable never rises without the chip enable, and the RAM is never enabled inside the register window or without its region's key. The top ROM window always carries bank 63, and the unmapped gap never selects anything. Ignored register writes leave the bank and key registers stable, and a bank write loads data bits 7:2. Only the bench's scenarios can show the exact key value for each region and that a near-miss key stays locked. They also show re-locking after a later write and the full ROM address in each window for a chosen bank. The reference model compares all six outputs against these rules on every clock during directed and random traffic.

// File: rtl/prgk_pkg.sv
package prgk_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int N_SLOTS  = 3;
  localparam int N_KEYS   = 3;
  localparam int BANK_W   = 6;
  localparam int OFS_W    = 13;
  localparam logic [11:0] REG_PAGE = 12'h7EF;
  localparam logic [3:0]  KEY_OFS  = 4'h7;
  localparam logic [3:0]  BANK_OFS = 4'hA;

  function automatic logic [DATA_W-1:0] key_of(input int idx);
    case (idx)
      0:       return 8'hCA;
      1:       return 8'h69;
      default: return 8'h84;
    endcase
  endfunction
endpackage

// File: rtl/prgk_regs.sv
module prgk_regs
  import prgk_pkg::*;
#(
  parameter int NS = N_SLOTS,
  parameter int NK = N_KEYS,
  parameter int BW = BANK_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       win_i,
  input  logic [3:0]                 ofs_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic [NS-1:0][BW-1:0]      bank_o,
  output logic [NK-1:0][DATA_W-1:0]  key_o
);
  logic wr_en;
  assign wr_en = wr_i & win_i;

  for (genvar s = 0; s < NS; s++) begin : g_bank
    localparam logic [3:0] A = BANK_OFS + 4'(s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 bank_o[s] <= '0;
      else if (wr_en && ofs_i == A) bank_o[s] <= data_i[DATA_W-1 -: BW];
    end
  end

  for (genvar k = 0; k < NK; k++) begin : g_key
    localparam logic [3:0] A = KEY_OFS + 4'(k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 key_o[k] <= '0;
      else if (wr_en && ofs_i == A) key_o[k] <= data_i;
    end
  end

  logic hit_bank, hit_key;
  assign hit_bank = wr_en && ofs_i >= BANK_OFS && ofs_i < BANK_OFS + 4'(NS);
  assign hit_key  = wr_en && ofs_i >= KEY_OFS  && ofs_i < KEY_OFS  + 4'(NK);

  p_bank_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_bank |=> $stable(bank_o));
  p_key_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_key |=> $stable(key_o));
  p_bank_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && ofs_i == BANK_OFS) |=> bank_o[0] == $past(data_i[DATA_W-1 -: BW]));
endmodule

// File: rtl/prgk_key_gate.sv
module prgk_key_gate
  import prgk_pkg::*;
#(
  parameter int NK = N_KEYS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NK-1:0][DATA_W-1:0]  key_i,
  output logic [NK-1:0]              unlock_o
);
  for (genvar k = 0; k < NK; k++) begin : g_cmp
    assign unlock_o[k] = (key_i[k] == key_of(k));
  end

  p_locked_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> unlock_o == '0);
endmodule

// File: rtl/prgk_addr_map.sv
module prgk_addr_map
  import prgk_pkg::*;
#(
  parameter int NS = N_SLOTS,
  parameter int NK = N_KEYS,
  parameter int BW = BANK_W,
  localparam int PRG_AW = BW + OFS_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [NS-1:0][BW-1:0]  bank_i,
  input  logic [NK-1:0]          unlock_i,
  output logic [PRG_AW-1:0]      prg_addr_o,
  output logic                   prg_ce_o,
  output logic [OFS_W-1:0]       ram_addr_o,
  output logic                   ram_ce_o,
  output logic                   ram_we_o,
  output logic                   reg_sel_o
);
  logic [1:0]    slot, region;
  logic [BW-1:0] sel_bank;
  logic          ram_win, region_open;

  assign slot   = addr_i[14:13];
  assign region = addr_i[12:11];

  always_comb begin
    sel_bank = '1;  // top window: last bank
    for (int s = 0; s < NS; s++)
      if (slot == 2'(s)) sel_bank = bank_i[s];
  end

  always_comb begin
    region_open = 1'b0;
    for (int k = 0; k < NK; k++)
      if (region == 2'(k)) region_open = unlock_i[k];
  end

  assign ram_win    = (addr_i[15:13] == 3'b011) && (!addr_i[12] || addr_i[11:10] == 2'b00);
  assign reg_sel_o  = (addr_i[15:4] == REG_PAGE);
  assign prg_ce_o   = addr_i[15] & rd_i;
  assign prg_addr_o = {sel_bank, addr_i[OFS_W-1:0]};
  assign ram_addr_o = addr_i[OFS_W-1:0];
  assign ram_ce_o   = ram_win & region_open & (rd_i | wr_i);
  assign ram_we_o   = ram_ce_o & wr_i;

  p_we_needs_ce_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_ce_o && wr_i));
  p_regwin_no_ram_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_o |-> !ram_ce_o);
  p_fixed_bank_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:13] == 3'b111) |-> (prg_addr_o[PRG_AW-1 -: BW] == '1));
  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= 16'h7400 && addr_i < 16'h7EF0) |-> !(ram_ce_o || reg_sel_o || prg_ce_o));
endmodule

// File: rtl/prg_ram_decoder.sv
module prg_ram_decoder
  import prgk_pkg::*;
#(
  parameter int BW = BANK_W,
  localparam int PRG_AW = BW + OFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_data_i,
  input  logic               cpu_rd_i,
  input  logic               cpu_wr_i,
  output logic [PRG_AW-1:0]  prg_addr_o,
  output logic               prg_ce_o,
  output logic [OFS_W-1:0]   ram_addr_o,
  output logic               ram_ce_o,
  output logic               ram_we_o,
  output logic               reg_sel_o
);
  logic [N_SLOTS-1:0][BW-1:0]     bank;
  logic [N_KEYS-1:0][DATA_W-1:0]  key;
  logic [N_KEYS-1:0]              unlock;

  prgk_regs #(.NS(N_SLOTS), .NK(N_KEYS), .BW(BW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cpu_wr_i),
    .win_i  (reg_sel_o),
    .ofs_i  (cpu_addr_i[3:0]),
    .data_i (cpu_data_i),
    .bank_o (bank),
    .key_o  (key)
  );

  prgk_key_gate #(.NK(N_KEYS)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .key_i    (key),
    .unlock_o (unlock)
  );

  prgk_addr_map #(.NS(N_SLOTS), .NK(N_KEYS), .BW(BW)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (cpu_addr_i),
    .rd_i       (cpu_rd_i),
    .wr_i       (cpu_wr_i),
    .bank_i     (bank),
    .unlock_i   (unlock),
    .prg_addr_o (prg_addr_o),
    .prg_ce_o   (prg_ce_o),
    .ram_addr_o (ram_addr_o),
    .ram_ce_o   (ram_ce_o),
    .ram_we_o   (ram_we_o),
    .reg_sel_o  (reg_sel_o)
  );

  // region of an enabled access must hold its key
  p_locked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_ce_o |-> ((cpu_addr_i[12:11] == 2'd0 && unlock[0]) ||
                  (cpu_addr_i[12:11] == 2'd1 && unlock[1]) ||
                  (cpu_addr_i[12:11] == 2'd2 && unlock[2])));
endmodule

// File: tb/prg_ram_decoder_test.sv
`timescale 1ns/1ps
module prg_ram_decoder_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic        rd = 1'b0, wr = 1'b0;
  logic [18:0] prg_addr;
  logic [12:0] ram_addr;
  logic        prg_ce, ram_ce, ram_we, reg_sel;

  int n_run = 0, n_fail = 0, cycles = 0;
  bit running = 0;
  int m_bank[3];
  int m_key[3];

  always #10 clk = ~clk;

  prg_ram_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(addr), .cpu_data_i(data),
    .cpu_rd_i(rd), .cpu_wr_i(wr), .prg_addr_o(prg_addr), .prg_ce_o(prg_ce),
    .ram_addr_o(ram_addr), .ram_ce_o(ram_ce), .ram_we_o(ram_we), .reg_sel_o(reg_sel)
  );

  // reference model state
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) begin m_bank[i] = 0; m_key[i] = 0; end
    end else if (wr) begin
      if (addr >= 16'h7EF7 && addr <= 16'h7EF9) m_key[addr - 16'h7EF7] = data;
      if (addr >= 16'h7EFA && addr <= 16'h7EFC) m_bank[addr - 16'h7EFA] = data >> 2;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s addr=%h actual=%0h expected=%0h", tag, what, addr, act, exp);
    end
  endtask

  function automatic int region_of(int a);
    if (a >= 16'h6000 && a < 16'h6800) return 0;
    if (a >= 16'h6800 && a < 16'h7000) return 1;
    if (a >= 16'h7000 && a < 16'h7400) return 2;
    return -1;
  endfunction

  function automatic bit open_region(int r);
    case (r)
      0: return m_key[0] == 8'hCA;
      1: return m_key[1] == 8'h69;
      2: return m_key[2] == 8'h84;
      default: return 0;
    endcase
  endfunction

  function automatic string ce_tag(int a);
    int r = region_of(a);
    if (r == 0) return open_region(0) ? "R7" : "R10";
    if (r == 1) return open_region(1) ? "R8" : "R10";
    if (r == 2) return open_region(2) ? "R9" : "R10";
    if (a >= 16'h7400 && a < 16'h7EF0) return "R11";
    return "R13";
  endfunction

  task automatic compare_all();
    int a = int'(addr);
    int r = region_of(a);
    int slot = a / 8192 - 4;
    bit e_ce = (r >= 0) && open_region(r) && (rd || wr);
    chk("R2", "reg_sel", int'(reg_sel), int'(a >= 16'h7EF0 && a <= 16'h7EFF));
    chk("R5", "prg_ce", int'(prg_ce), int'(a >= 16'h8000 && rd));
    if (a >= 16'hE000)
      chk("R4", "prg_addr", int'(prg_addr), 63 * 8192 + a % 8192);
    else if (a >= 16'h8000)
      chk("R3", "prg_addr", int'(prg_addr), m_bank[slot] * 8192 + a % 8192);
    chk(ce_tag(a), "ram_ce", int'(ram_ce), int'(e_ce));
    chk("R13", "ram_we", int'(ram_we), int'(e_ce && wr));
    if (r >= 0) chk("R6", "ram_addr", int'(ram_addr), a - 16'h6000);
  endtask

  always @(negedge clk) begin
    #5;
    if (running && rst_ni) compare_all();
  end

  // drive at negedge; return after the per-cycle compare
  task automatic acc(input logic [15:0] a, input logic [7:0] d, input bit r, input bit w);
    @(negedge clk);
    addr = a; data = d; rd = r; wr = w;
    #6;
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    acc(a, d, 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    #1;
    addr = 16'h6000; rd = 1;
    #1 chk("R1", "ram_ce in reset", int'(ram_ce), 0);
    rst_ni = 1'b1;
    running = 1;
    // R1: after release all locked, banks 0
    acc(16'h6000, 0, 1, 0); chk("R1", "region0 locked", int'(ram_ce), 0);
    acc(16'h6800, 0, 0, 1); chk("R1", "region1 locked", int'(ram_ce), 0);
    acc(16'h7000, 0, 1, 0); chk("R1", "region2 locked", int'(ram_ce), 0);
    acc(16'hA123, 0, 1, 0); chk("R1", "bank a000", int'(prg_addr), 16'h0123);
    // R10: near-miss keys keep regions locked
    wr_reg(16'h7EF7, 8'hCB); wr_reg(16'h7EF8, 8'h68); wr_reg(16'h7EF9, 8'h85);
    acc(16'h6000, 8'h11, 0, 1); chk("R10", "write locked r0", int'(ram_we), 0);
    acc(16'h6C00, 0, 1, 0);     chk("R10", "read locked r1", int'(ram_ce), 0);
    acc(16'h7200, 0, 1, 0);     chk("R10", "read locked r2", int'(ram_ce), 0);
    // R7: region 0 key
    wr_reg(16'h7EF7, 8'hCA);
    acc(16'h6000, 0, 1, 0); chk("R7", "r0 read", int'(ram_ce), 1);
    acc(16'h67FF, 8'h5A, 0, 1); chk("R7", "r0 write", int'(ram_we), 1);
    acc(16'h6800, 0, 1, 0); chk("R8", "r1 still locked", int'(ram_ce), 0);
    acc(16'h6400, 0, 0, 0); chk("R13", "no strobe", int'(ram_ce), 0);
    // R8, R9
    wr_reg(16'h7EF8, 8'h69); wr_reg(16'h7EF9, 8'h84);
    acc(16'h6800, 0, 1, 0); chk("R8", "r1 read", int'(ram_ce), 1);
    acc(16'h6FFF, 1, 0, 1); chk("R8", "r1 write", int'(ram_we), 1);
    acc(16'h7000, 0, 1, 0); chk("R9", "r2 read", int'(ram_ce), 1);
    acc(16'h73FF, 2, 0, 1); chk("R9", "r2 write", int'(ram_we), 1);
    acc(16'h73FF, 0, 1, 0); chk("R6", "r2 ram_addr", int'(ram_addr), 16'h13FF);
    // R11: gap unmapped
    acc(16'h7400, 0, 1, 0); chk("R11", "7400", int'(ram_ce | reg_sel | prg_ce), 0);
    acc(16'h7EEF, 3, 0, 1); chk("R11", "7eef", int'(ram_ce | reg_sel | prg_ce), 0);
    // R13: register window never reaches RAM
    acc(16'h7EF7, 8'hCA, 0, 1); chk("R13", "regwin ram_ce", int'(ram_ce), 0);
    // R3: bank loads, R4 fixed bank
    wr_reg(16'h7EFA, 8'h14); wr_reg(16'h7EFB, 8'hFB); wr_reg(16'h7EFC, 8'h03);
    acc(16'h8000, 0, 1, 0); chk("R3", "8000", int'(prg_addr), 5 * 8192);
    acc(16'hBFFF, 0, 1, 0); chk("R3", "bfff", int'(prg_addr), 62 * 8192 + 16'h1FFF);
    acc(16'hC123, 0, 1, 0); chk("R3", "c123", int'(prg_addr), 16'h0123);
    acc(16'hE000, 0, 1, 0); chk("R4", "e000", int'(prg_addr), 63 * 8192);
    acc(16'hFFFF, 0, 0, 0); chk("R5", "no rd", int'(prg_ce), 0);
    // R12: ignored register writes
    for (int i = 0; i < 16; i++)
      if (i < 7 || i > 12) wr_reg(16'h7EF0 + 16'(i), 8'h00);
    acc(16'h8000, 0, 1, 0); chk("R12", "bank0 kept", int'(prg_addr), 5 * 8192);
    acc(16'hA000, 0, 1, 0); chk("R12", "bank1 kept", int'(prg_addr), 62 * 8192);
    acc(16'h6000, 0, 1, 0); chk("R12", "key0 kept", int'(ram_ce), 1);
    acc(16'h7000, 0, 1, 0); chk("R12", "key2 kept", int'(ram_ce), 1);
    // R10: relock
    wr_reg(16'h7EF8, 8'h00);
    acc(16'h6800, 7, 0, 1); chk("R10", "r1 relocked", int'(ram_we), 0);
    acc(16'h6000, 0, 1, 0); chk("R10", "r0 unaffected", int'(ram_ce), 1);
    // random traffic, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic [7:0] d;
      int pick = $urandom_range(0, 9);
      a = 16'($urandom);
      if (pick < 3) a = 16'h7EF0 + 16'($urandom_range(0, 15));
      else if (pick < 6) a = 16'h6000 + 16'($urandom_range(0, 16'h1FFF));
      d = 8'($urandom);
      if (pick == 3 && $urandom_range(0, 1) == 1) d = 8'hCA;
      if (pick == 4 && $urandom_range(0, 1) == 1) d = 8'h69;
      if (pick == 5 && $urandom_range(0, 1) == 1) d = 8'h84;
      if (a >= 16'h7EF7 && a <= 16'h7EF9 && $urandom_range(0, 1) == 1)
        d = (a == 16'h7EF7) ? 8'hCA : (a == 16'h7EF8) ? 8'h69 : 8'h84;
      acc(a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    running = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule